// File: doc/BRIEF.md
# Multicycle Processor Sequencing Controller

This block is the control unit of a small multicycle processor that handles register-register add and subtract, OR with an immediate, word load, word store and branch-on-equal. Each instruction is broken into short steps (fetch, decode, execute, memory access, write-back), one step per clock cycle. The controller holds a 4-bit step code and, from that code alone, drives every enable and select the datapath needs. The one exception is the ALU operation in the register-register execute step, which follows the function field held in the instruction register.

The datapath supplies the opcode and function fields of the held instruction and a flag that says whether the two source registers are equal. The branch is resolved during decode using that flag, so a branch takes three cycles. Register-register and OR-immediate instructions take four cycles, a store takes four and a load takes five. Every register transfer that a step requests happens on the clock edge that leaves that step. Exactly one step in each instruction, the last one, advances the program counter.

Top module: `mcyc_ctrl`

## Requirements
- R1: An asynchronous active-low reset puts the controller in the fetch step at once. While in fetch, only `ir_en` and `imem_rd` are 1, and every other output is 0.
- R2: Fetch always moves to decode. Decode asserts only `a_en` and `b_en`.
- R3: In decode, the opcode chooses the path: 0x00 is register-register, 0x0D is OR-immediate, 0x23 is load, 0x2B is store and 0x04 is branch.
- R4: A branch with `regs_equal`=1 in decode takes 3 cycles. Its third cycle asserts only `pc_en` with `pc_src`=1 (branch target).
- R5: A branch with `regs_equal`=0 in decode takes 3 cycles. Its third cycle asserts only `pc_en` with `pc_src`=0 (PC plus 4).
- R6: Register-register has two steps after decode. The execute step asserts `s_en` with `alu_sel_b`=0 (register B). It sets `alu_op`=1 (subtract) when the function code is 0x22 and `alu_op`=0 (add) for any other function code. The write-back step asserts `reg_wr`, `reg_dst`=1 (rd), `wb_sel`=0 (S) and `pc_en` with `pc_src`=0.
- R7: OR-immediate has two steps after decode. The execute step asserts `s_en`, `alu_op`=2 (OR) and `alu_sel_b`=2 (zero-extended immediate). The write-back step asserts `reg_wr`, `reg_dst`=0 (rt), `wb_sel`=0 and `pc_en`.
- R8: Load has three steps after decode. The execute step asserts `s_en`, `alu_op`=0 and `alu_sel_b`=1 (sign-extended immediate). The memory step asserts `m_en` and `dmem_rd`. The write-back step asserts `reg_wr`, `reg_dst`=0, `wb_sel`=1 (M) and `pc_en`.
- R9: Store has two steps after decode. The execute step matches the load execute step. The memory step asserts `dmem_wr` and `pc_en` with `pc_src`=0.
- R10: Any other opcode in decode returns to fetch on the next edge. No write enable is asserted along the way.
- R11: At most one of `imem_rd`, `dmem_rd` and `dmem_wr` is 1 in any cycle. Every cycle with `pc_en`=1 is followed by a fetch cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Opcode field of the held instruction |
| funct | input | 6 | Function field of the held instruction |
| regs_equal | input | 1 | Datapath flag: register A equals register B |
| ir_en | output | 1 | Load instruction register |
| a_en | output | 1 | Load operand register A |
| b_en | output | 1 | Load operand register B |
| s_en | output | 1 | Load ALU result register S |
| m_en | output | 1 | Load memory data register M |
| pc_en | output | 1 | Load program counter |
| pc_src | output | 1 | PC source: 0 PC plus 4, 1 branch target |
| imem_rd | output | 1 | Instruction memory read |
| dmem_rd | output | 1 | Data memory read |
| dmem_wr | output | 1 | Data memory write |
| reg_wr | output | 1 | Register file write |
| reg_dst | output | 1 | Destination: 0 rt, 1 rd |
| wb_sel | output | 1 | Write-back data: 0 S, 1 M |
| alu_op | output | 2 | ALU operation: 0 add, 1 subtract, 2 OR |
| alu_sel_b | output | 2 | ALU B operand: 0 register B, 1 sign-extended, 2 zero-extended |

## Verification
The hardest case to reach from the ports is a reset that arrives partway through an instruction, such as during the load memory step. The stimulus drives a load opcode and lets the controller run three edges without a scoreboard entry. It confirms the memory step is active, then pulls reset low between clock edges and checks the fetch outputs before the next edge. The other hard case is an opcode that matches no path, because the only sign of it is the early return to fetch. The scoreboard expects a sequence of exactly two steps for it, so any extra step shows up as a mismatch.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;

  localparam int OPC_W = 6;
  localparam int FN_W  = 6;
  localparam int ST_W  = 4;

  localparam logic [OPC_W-1:0] OPC_RR   = 6'h00;
  localparam logic [OPC_W-1:0] OPC_ORI  = 6'h0D;
  localparam logic [OPC_W-1:0] OPC_LOAD = 6'h23;
  localparam logic [OPC_W-1:0] OPC_STOR = 6'h2B;
  localparam logic [OPC_W-1:0] OPC_BREQ = 6'h04;

  localparam logic [FN_W-1:0]  FN_SUB   = 6'h22;

  typedef enum logic [ST_W-1:0] {
    ST_FETCH   = 4'b0000,
    ST_DECODE  = 4'b0001,
    ST_BR_TAKE = 4'b0010,
    ST_BR_SKIP = 4'b0011,
    ST_RR_EXE  = 4'b0100,
    ST_RR_WB   = 4'b0101,
    ST_OI_EXE  = 4'b0110,
    ST_OI_WB   = 4'b0111,
    ST_LD_EXE  = 4'b1000,
    ST_LD_MEM  = 4'b1001,
    ST_LD_WB   = 4'b1010,
    ST_SW_EXE  = 4'b1011,
    ST_SW_MEM  = 4'b1100
  } step_e;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_OR  = 2'd2
  } alu_op_e;

  typedef enum logic [1:0] {
    OPB_REG  = 2'd0,
    OPB_SEXT = 2'd1,
    OPB_ZEXT = 2'd2
  } opb_e;

  typedef struct packed {
    logic    ir_en;
    logic    a_en;
    logic    b_en;
    logic    s_en;
    logic    m_en;
    logic    pc_en;
    logic    pc_src;
    logic    imem_rd;
    logic    dmem_rd;
    logic    dmem_wr;
    logic    reg_wr;
    logic    reg_dst;
    logic    wb_sel;
    alu_op_e alu_op;
    opb_e    alu_sel_b;
  } ctrl_t;

endpackage

// File: rtl/mcyc_step_reg.sv
module mcyc_step_reg
  import mcyc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  step_e step_d,
  output step_e step_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= ST_FETCH;
    end else begin
      step_q <= step_d;
    end
  end

endmodule

// File: rtl/mcyc_next_step.sv
module mcyc_next_step
  import mcyc_pkg::*;
(
  input  step_e            cur,
  input  logic [OPC_W-1:0] opcode,
  input  logic             regs_equal,
  output step_e            nxt
);

  step_e dispatch;

  always_comb begin
    unique case (opcode)
      OPC_RR:   dispatch = ST_RR_EXE;
      OPC_ORI:  dispatch = ST_OI_EXE;
      OPC_LOAD: dispatch = ST_LD_EXE;
      OPC_STOR: dispatch = ST_SW_EXE;
      OPC_BREQ: dispatch = regs_equal ? ST_BR_TAKE : ST_BR_SKIP;
      default:  dispatch = ST_FETCH;
    endcase
  end

  always_comb begin
    case (cur)
      ST_FETCH:  nxt = ST_DECODE;
      ST_DECODE: nxt = dispatch;
      ST_RR_EXE: nxt = ST_RR_WB;
      ST_OI_EXE: nxt = ST_OI_WB;
      ST_LD_EXE: nxt = ST_LD_MEM;
      ST_LD_MEM: nxt = ST_LD_WB;
      ST_SW_EXE: nxt = ST_SW_MEM;
      default:   nxt = ST_FETCH;
    endcase
  end

endmodule

// File: rtl/mcyc_out_decode.sv
module mcyc_out_decode
  import mcyc_pkg::*;
(
  input  step_e           cur,
  input  logic [FN_W-1:0] funct,
  output ctrl_t           ctl
);

  alu_op_e rr_op;

  always_comb begin
    rr_op = (funct == FN_SUB) ? ALU_SUB : ALU_ADD;
  end

  always_comb begin
    ctl = '{default: '0, alu_op: ALU_ADD, alu_sel_b: OPB_REG};
    case (cur)
      ST_FETCH: begin
        ctl.ir_en   = 1'b1;
        ctl.imem_rd = 1'b1;
      end
      ST_DECODE: begin
        ctl.a_en = 1'b1;
        ctl.b_en = 1'b1;
      end
      ST_BR_TAKE: begin
        ctl.pc_en  = 1'b1;
        ctl.pc_src = 1'b1;
      end
      ST_BR_SKIP: begin
        ctl.pc_en = 1'b1;
      end
      ST_RR_EXE: begin
        ctl.s_en      = 1'b1;
        ctl.alu_op    = rr_op;
        ctl.alu_sel_b = OPB_REG;
      end
      ST_RR_WB: begin
        ctl.reg_wr  = 1'b1;
        ctl.reg_dst = 1'b1;
        ctl.pc_en   = 1'b1;
      end
      ST_OI_EXE: begin
        ctl.s_en      = 1'b1;
        ctl.alu_op    = ALU_OR;
        ctl.alu_sel_b = OPB_ZEXT;
      end
      ST_OI_WB: begin
        ctl.reg_wr = 1'b1;
        ctl.pc_en  = 1'b1;
      end
      ST_LD_EXE, ST_SW_EXE: begin
        ctl.s_en      = 1'b1;
        ctl.alu_op    = ALU_ADD;
        ctl.alu_sel_b = OPB_SEXT;
      end
      ST_LD_MEM: begin
        ctl.m_en    = 1'b1;
        ctl.dmem_rd = 1'b1;
      end
      ST_LD_WB: begin
        ctl.reg_wr = 1'b1;
        ctl.wb_sel = 1'b1;
        ctl.pc_en  = 1'b1;
      end
      ST_SW_MEM: begin
        ctl.dmem_wr = 1'b1;
        ctl.pc_en   = 1'b1;
      end
      default: begin
      end
    endcase
  end

endmodule

// File: rtl/mcyc_ctrl.sv
module mcyc_ctrl
  import mcyc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] opcode,
  input  logic [FN_W-1:0]  funct,
  input  logic             regs_equal,
  output logic             ir_en,
  output logic             a_en,
  output logic             b_en,
  output logic             s_en,
  output logic             m_en,
  output logic             pc_en,
  output logic             pc_src,
  output logic             imem_rd,
  output logic             dmem_rd,
  output logic             dmem_wr,
  output logic             reg_wr,
  output logic             reg_dst,
  output logic             wb_sel,
  output logic [1:0]       alu_op,
  output logic [1:0]       alu_sel_b
);

  step_e step_q;
  step_e step_d;
  ctrl_t ctl;

  mcyc_step_reg u_step_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .step_d (step_d),
    .step_q (step_q)
  );

  mcyc_next_step u_next_step (
    .cur        (step_q),
    .opcode     (opcode),
    .regs_equal (regs_equal),
    .nxt        (step_d)
  );

  mcyc_out_decode u_out_decode (
    .cur   (step_q),
    .funct (funct),
    .ctl   (ctl)
  );

  assign ir_en     = ctl.ir_en;
  assign a_en      = ctl.a_en;
  assign b_en      = ctl.b_en;
  assign s_en      = ctl.s_en;
  assign m_en      = ctl.m_en;
  assign pc_en     = ctl.pc_en;
  assign pc_src    = ctl.pc_src;
  assign imem_rd   = ctl.imem_rd;
  assign dmem_rd   = ctl.dmem_rd;
  assign dmem_wr   = ctl.dmem_wr;
  assign reg_wr    = ctl.reg_wr;
  assign reg_dst   = ctl.reg_dst;
  assign wb_sel    = ctl.wb_sel;
  assign alu_op    = ctl.alu_op;
  assign alu_sel_b = ctl.alu_sel_b;

endmodule

// File: rtl/mcyc_ctrl_chk.sv
module mcyc_ctrl_chk
  import mcyc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [OPC_W-1:0] opcode,
  input logic [FN_W-1:0]  funct,
  input logic             regs_equal,
  input logic             ir_en,
  input logic             a_en,
  input logic             b_en,
  input logic             s_en,
  input logic             m_en,
  input logic             pc_en,
  input logic             pc_src,
  input logic             imem_rd,
  input logic             dmem_rd,
  input logic             dmem_wr,
  input logic             reg_wr,
  input logic             reg_dst,
  input logic             wb_sel,
  input logic [1:0]       alu_op,
  input logic [1:0]       alu_sel_b
);

  logic known_op;
  assign known_op = (opcode == OPC_RR) || (opcode == OPC_ORI) ||
                    (opcode == OPC_LOAD) || (opcode == OPC_STOR) ||
                    (opcode == OPC_BREQ);

  a_r2_fetch_then_decode: assert property (@(posedge clk) disable iff (!rst_n)
    ir_en |=> (a_en && b_en && !ir_en));

  a_r11_mem_port_single: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({imem_rd, dmem_rd, dmem_wr}));

  a_r11_pc_then_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    pc_en |=> (ir_en && imem_rd));

  a_r4_taken_branch: assert property (@(posedge clk) disable iff (!rst_n)
    (a_en && opcode == OPC_BREQ && regs_equal) |=> (pc_en && pc_src && !reg_wr));

  a_r5_skipped_branch: assert property (@(posedge clk) disable iff (!rst_n)
    (a_en && opcode == OPC_BREQ && !regs_equal) |=> (pc_en && !pc_src && !reg_wr));

  a_r6_rr_execute: assert property (@(posedge clk) disable iff (!rst_n)
    (a_en && opcode == OPC_RR) |=> (s_en && alu_sel_b == 2'd0));

  a_r8_load_mem_then_wb: assert property (@(posedge clk) disable iff (!rst_n)
    m_en |=> (reg_wr && wb_sel && pc_en));

  a_r10_unknown_back: assert property (@(posedge clk) disable iff (!rst_n)
    (a_en && !known_op) |=> (ir_en && !reg_wr && !dmem_wr && !pc_en));

endmodule

bind mcyc_ctrl mcyc_ctrl_chk u_chk (.*);

// File: tb/test_mcyc_ctrl.sv
`timescale 1ns/1ps
module test_mcyc_ctrl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] opcode;
  logic [5:0] funct;
  logic       regs_equal;
  logic       ir_en, a_en, b_en, s_en, m_en, pc_en, pc_src;
  logic       imem_rd, dmem_rd, dmem_wr, reg_wr, reg_dst, wb_sel;
  logic [1:0] alu_op, alu_sel_b;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  logic [16:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  mcyc_ctrl i_mcyc_ctrl (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .funct(funct),
    .regs_equal(regs_equal), .ir_en(ir_en), .a_en(a_en), .b_en(b_en),
    .s_en(s_en), .m_en(m_en), .pc_en(pc_en), .pc_src(pc_src),
    .imem_rd(imem_rd), .dmem_rd(dmem_rd), .dmem_wr(dmem_wr),
    .reg_wr(reg_wr), .reg_dst(reg_dst), .wb_sel(wb_sel),
    .alu_op(alu_op), .alu_sel_b(alu_sel_b)
  );

  function automatic logic [16:0] actual();
    return {ir_en, a_en, b_en, s_en, m_en, pc_en, pc_src, imem_rd, dmem_rd,
            dmem_wr, reg_wr, reg_dst, wb_sel, alu_op, alu_sel_b};
  endfunction

  // field order: ir a b s m pc pcsrc imem drd dwr rw dst wb op[2] selb[2]
  function automatic logic [16:0] mk(input logic ir, a, b, s, m, pc, ps,
                                     im, dr, dw, rw, dst, wb,
                                     input logic [1:0] op, sb);
    return {ir, a, b, s, m, pc, ps, im, dr, dw, rw, dst, wb, op, sb};
  endfunction

  function automatic logic [16:0] v_fetch();
    return mk(1,0,0,0,0,0,0,1,0,0,0,0,0,2'd0,2'd0);
  endfunction

  function automatic logic [16:0] v_decode();
    return mk(0,1,1,0,0,0,0,0,0,0,0,0,0,2'd0,2'd0);
  endfunction

  task automatic check(input logic [16:0] exp, input string tag);
    checks++;
    if (actual() !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, actual(), exp);
    end
  endtask

  task automatic push(input logic [16:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  // driver: applies instruction fields and queues the step-by-step outputs
  task automatic issue(input logic [5:0] op, input logic [5:0] fn,
                       input logic eq, input string tag);
    int n;
    opcode = op; funct = fn; regs_equal = eq;
    push(v_fetch(), {tag, " fetch R1 R2"});
    push(v_decode(), {tag, " decode R2 R3"});
    n = 2;
    case (op)
      6'h04: begin
        push(mk(0,0,0,0,0,1,eq,0,0,0,0,0,0,2'd0,2'd0), {tag, " branch R4 R5"});
        n = 3;
      end
      6'h00: begin
        push(mk(0,0,0,1,0,0,0,0,0,0,0,0,0,(fn == 6'h22) ? 2'd1 : 2'd0,2'd0),
             {tag, " exe R6"});
        push(mk(0,0,0,0,0,1,0,0,0,0,1,1,0,2'd0,2'd0), {tag, " wb R6"});
        n = 4;
      end
      6'h0D: begin
        push(mk(0,0,0,1,0,0,0,0,0,0,0,0,0,2'd2,2'd2), {tag, " exe R7"});
        push(mk(0,0,0,0,0,1,0,0,0,0,1,0,0,2'd0,2'd0), {tag, " wb R7"});
        n = 4;
      end
      6'h23: begin
        push(mk(0,0,0,1,0,0,0,0,0,0,0,0,0,2'd0,2'd1), {tag, " exe R8"});
        push(mk(0,0,0,0,1,0,0,0,1,0,0,0,0,2'd0,2'd0), {tag, " mem R8"});
        push(mk(0,0,0,0,0,1,0,0,0,0,1,0,1,2'd0,2'd0), {tag, " wb R8"});
        n = 5;
      end
      6'h2B: begin
        push(mk(0,0,0,1,0,0,0,0,0,0,0,0,0,2'd0,2'd1), {tag, " exe R9"});
        push(mk(0,0,0,0,0,1,0,0,0,1,0,0,0,2'd0,2'd0), {tag, " mem R9"});
        n = 4;
      end
      default: n = 2;
    endcase
    repeat (n) @(posedge clk);
    #2;
  endtask

  // monitor: compares the design against the scoreboard mid-cycle
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [16:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(e, t);
    end
  end

  initial begin
    rst_n = 1'b0; opcode = '0; funct = '0; regs_equal = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(v_fetch(), "R1 reset state");
    @(posedge clk); #2;
    rst_n = 1'b1;

    issue(6'h04, 6'h00, 1'b1, "beq taken R4");
    issue(6'h04, 6'h00, 1'b0, "beq skip R5");
    issue(6'h00, 6'h20, 1'b0, "rr add R6");
    issue(6'h00, 6'h22, 1'b1, "rr sub R6");
    issue(6'h00, 6'h25, 1'b0, "rr other fn R6");
    issue(6'h0D, 6'h22, 1'b0, "ori R7");
    issue(6'h23, 6'h00, 1'b1, "load R8");
    issue(6'h2B, 6'h00, 1'b0, "store R9");
    issue(6'h3F, 6'h00, 1'b1, "undefined R10");
    issue(6'h01, 6'h00, 1'b0, "undefined R10 b");
    issue(6'h2B, 6'h00, 1'b1, "store after R11");

    // reset in the middle of a load memory step (R1)
    opcode = 6'h23; funct = '0; regs_equal = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check(mk(0,0,0,0,1,0,0,0,1,0,0,0,0,2'd0,2'd0), "R8 mid-load mem step");
    rst_n = 1'b0;
    #1;
    check(v_fetch(), "R1 async reset mid-instruction");
    @(posedge clk); #2;
    rst_n = 1'b1;
    @(negedge clk);
    check(v_fetch(), "R1 fetch after release");
    @(posedge clk); #2;
    check(v_decode(), "R2 decode after release");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired R11 actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule